// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether a received frame whose destination address is a group (multicast) address should be accepted. It runs the Ethernet CRC-32 over the 48-bit destination address and keeps eight bits of the result as a hash index. That index selects one bit of a 256-entry group table, and the block reports the selected bit as an accept flag. The address arrives in one of two ways. It can come in as a stream of six bytes, one byte per clock. It can also come in as a single 48-bit word with a valid strobe.

The table is held in eight 32-bit registers. A host can write and read each register as a whole. It can also set or clear one entry by giving its 8-bit index. Addresses whose group bit is clear are never accepted here, because exact-match station filtering belongs to a different block.

Top module: `mcast_hash_filter`

## Requirements
- R1: The hash CRC uses the reflected polynomial 0xEDB88320 and starts from 0xFFFFFFFF, with no final inversion. It shifts right, and it feeds each address byte least-significant bit first, beginning with the first byte. The 8-bit hash index is the top byte of the bit-reversed CRC, so index bit 7-k equals CRC bit k for k = 0..7.
- R2: Index bits [7:5] select table register 0..7. Index bits [4:0] select bit 31 minus that value inside the register, so entry 0 is bit 31 of register 0 and entry 255 is bit 0 of register 7. `accept` is the selected table bit ANDed with the address group bit.
- R3: In byte mode, `byteStart` with `byteValid` marks the first byte. The sixth accepted byte completes the lookup. Idle cycles with `byteValid` low may occur between bytes. `resultValid` pulses for exactly one cycle, one clock after the sixth byte. `hashIndex` and `accept` are valid during that pulse.
- R4: In word mode, `addrWord[7:0]` is the first byte on the wire and `addrWord[47:40]` is the last. A `wordValid` pulse gives `resultValid` on the next clock. A word abandons any byte sequence that is in progress.
- R5: The group bit is bit 0 of the first address byte. When that bit is 0, `accept` is 0 whatever the table holds.
- R6: `cmdSet` sets and `cmdClr` clears the entry at `cmdIndex`, and every other entry keeps its value. If both are high, the clear wins. If `regWrEn` is high in the same cycle, both commands are dropped.
- R7: `regWrEn` writes `regWrData` into register `regAddr`. `regRdData` always shows register `regAddr` without any clock delay.
- R8: After reset, all eight table registers read zero and `resultValid` and `accept` are low.
- R9: A lookup uses the table as it stood before the clock edge that takes the completing byte or word. A table change made on that same edge affects only later lookups.
- R10: Bytes with `byteValid` high that arrive when no sequence is open (no `byteStart`) are ignored and produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | Address byte present |
| byteStart | input | 1 | Current byte is the first address byte |
| byteData | input | 8 | Address byte |
| wordValid | input | 1 | Whole address present on addrWord |
| addrWord | input | 48 | Whole address, first wire byte in [7:0] |
| regWrEn | input | 1 | Table register write strobe |
| regAddr | input | 3 | Table register select for write and read |
| regWrData | input | 32 | Table register write data |
| regRdData | output | 32 | Contents of the selected table register |
| cmdSet | input | 1 | Set the entry at cmdIndex |
| cmdClr | input | 1 | Clear the entry at cmdIndex |
| cmdIndex | input | 8 | Entry index for set and clear |
| resultValid | output | 1 | One-cycle result strobe |
| accept | output | 1 | Frame accepted by the group filter |
| hashIndex | output | 8 | Hash index of the last lookup |

## Verification
A corrupted CRC register would show up as a wrong `hashIndex` on the result pulse of the same address. That pulse comes one cycle after the last byte, and the bench compares it against an independently computed hash in both input modes. A byte counter that slips would move the result pulse off its expected cycle or drop it entirely. A table bit stored in the wrong place shows up twice: immediately on `regRdData`, and as a wrong `accept` on the next lookup that hashes to that entry.

// File: rtl/mcast_hash_pkg.sv
package mcast_hash_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = ADDR_BYTES * 8;
  localparam int TBL_WORDS  = 8;
  localparam int TBL_W      = 32;
  localparam int IDX_W      = $clog2(TBL_WORDS * TBL_W);
  localparam int ROW_W      = $clog2(TBL_WORDS);
  localparam int BIT_W      = $clog2(TBL_W);
  localparam int CNT_W      = $clog2(ADDR_BYTES + 1);
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT = 32'hFFFFFFFF;

  typedef struct packed {
    logic crcLoad;     // first byte: seed CRC and capture group bit
    logic crcStep;     // later byte: fold into CRC
    logic byteLookup;  // this byte completes the address
    logic wordLookup;  // whole-word lookup this cycle
  } strobeT;

  function automatic logic [31:0] crcByte(input logic [31:0] crcIn, input logic [7:0] dataIn);
    logic [31:0] c;
    c = crcIn;
    for (int b = 0; b < 8; b++) begin
      if (c[0] ^ dataIn[b]) c = (c >> 1) ^ CRC_POLY;
      else                  c = c >> 1;
    end
    return c;
  endfunction

  function automatic logic [31:0] crcWord(input logic [ADDR_W-1:0] w);
    logic [31:0] c;
    c = CRC_INIT;
    for (int k = 0; k < ADDR_BYTES; k++) c = crcByte(c, w[8*k +: 8]);
    return c;
  endfunction

  function automatic logic [IDX_W-1:0] hashOf(input logic [31:0] c);
    logic [IDX_W-1:0] h;
    for (int k = 0; k < IDX_W; k++) h[IDX_W-1-k] = c[k];
    return h;
  endfunction
endpackage

// File: rtl/mcast_hash_ctrl.sv
module mcast_hash_ctrl
  import mcast_hash_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   byteValid,
  input  logic   byteStart,
  input  logic   wordValid,
  output strobeT stb
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0] byteCnt;  // bytes taken in the open sequence, 0 = none open

  always_comb begin
    stb = '0;
    if (wordValid) begin
      stb.wordLookup = 1'b1;
    end else if (byteValid && byteStart) begin
      stb.crcLoad = 1'b1;
    end else if (byteValid && byteCnt != '0) begin
      stb.crcStep    = 1'b1;
      stb.byteLookup = (byteCnt == LAST_CNT);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt <= '0;
    end else if (stb.wordLookup || stb.byteLookup) begin
      byteCnt <= '0;
    end else if (stb.crcLoad) begin
      byteCnt <= CNT_W'(1);
    end else if (stb.crcStep) begin
      byteCnt <= byteCnt + CNT_W'(1);
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt < CNT_W'(ADDR_BYTES)); // R3
  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && byteStart && !wordValid) |=> byteCnt == CNT_W'(1)); // R3
  AST_WORD_ABORTS: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> byteCnt == '0); // R4
  AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !byteStart && !wordValid && byteCnt == '0) |=> byteCnt == '0); // R10
endmodule

// File: rtl/mcast_hash_dp.sv
module mcast_hash_dp
  import mcast_hash_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [7:0]        byteData,
  input  logic [ADDR_W-1:0] addrWord,
  input  logic              regWrEn,
  input  logic [ROW_W-1:0]  regAddr,
  input  logic [TBL_W-1:0]  regWrData,
  output logic [TBL_W-1:0]  regRdData,
  input  logic              cmdSet,
  input  logic              cmdClr,
  input  logic [IDX_W-1:0]  cmdIndex,
  output logic              resultValid,
  output logic              accept,
  output logic [IDX_W-1:0]  hashIndex
);
  logic [TBL_W-1:0] tbl [TBL_WORDS];
  logic [31:0]      crcReg;
  logic             grpReg;
  logic [31:0]      crcFolded;
  logic [31:0]      lookupCrc;
  logic [IDX_W-1:0] lookupIdx;
  logic             grpNow;
  logic             lookupAny;
  logic [ROW_W-1:0] cmdRow;
  logic [BIT_W-1:0] cmdBit;
  logic [ROW_W-1:0] lkRow;
  logic [BIT_W-1:0] lkBit;

  assign crcFolded = crcByte(stb.crcLoad ? CRC_INIT : crcReg, byteData);
  assign lookupCrc = stb.wordLookup ? crcWord(addrWord) : crcFolded;
  assign lookupIdx = hashOf(lookupCrc);
  assign grpNow    = stb.wordLookup ? addrWord[0] : grpReg;
  assign lookupAny = stb.wordLookup | stb.byteLookup;

  // MSB-first numbering inside a register: bit = (TBL_W-1) - low index bits
  assign cmdRow = cmdIndex[IDX_W-1 -: ROW_W];
  assign cmdBit = ~cmdIndex[BIT_W-1:0];
  assign lkRow  = lookupIdx[IDX_W-1 -: ROW_W];
  assign lkBit  = ~lookupIdx[BIT_W-1:0];

  assign regRdData = tbl[regAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg <= CRC_INIT;
      grpReg <= 1'b0;
    end else if (stb.crcLoad || stb.crcStep) begin
      crcReg <= crcFolded;
      if (stb.crcLoad) grpReg <= byteData[0];
    end
  end

  generate
    for (genvar r = 0; r < TBL_WORDS; r++) begin : g_row
      always_ff @(posedge clk) begin
        if (!rstN) begin
          tbl[r] <= '0;
        end else if (regWrEn) begin
          if (regAddr == ROW_W'(r)) tbl[r] <= regWrData;
        end else if (cmdRow == ROW_W'(r)) begin
          if (cmdClr)      tbl[r][cmdBit] <= 1'b0;
          else if (cmdSet) tbl[r][cmdBit] <= 1'b1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      accept      <= 1'b0;
      hashIndex   <= '0;
    end else begin
      resultValid <= lookupAny;
      accept      <= lookupAny & grpNow & tbl[lkRow][lkBit];
      if (lookupAny) hashIndex <= lookupIdx;
    end
  end

  AST_RESULT_TIMING: assert property (@(posedge clk) disable iff (!rstN)
    lookupAny |=> resultValid); // R3
  AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !lookupAny |=> !resultValid); // R10
  AST_ACCEPT_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> resultValid); // R2
  AST_UNICAST_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (lookupAny && !grpNow) |=> !accept); // R5
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> tbl[$past(regAddr)] == $past(regWrData)); // R7
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
  import mcast_hash_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        byteValid,
  input  logic        byteStart,
  input  logic [7:0]  byteData,
  input  logic        wordValid,
  input  logic [47:0] addrWord,
  input  logic        regWrEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        cmdSet,
  input  logic        cmdClr,
  input  logic [7:0]  cmdIndex,
  output logic        resultValid,
  output logic        accept,
  output logic [7:0]  hashIndex
);
  strobeT stb;

  mcast_hash_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .byteValid (byteValid),
    .byteStart (byteStart),
    .wordValid (wordValid),
    .stb       (stb)
  );

  mcast_hash_dp dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .byteData    (byteData),
    .addrWord    (addrWord),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .cmdSet      (cmdSet),
    .cmdClr      (cmdClr),
    .cmdIndex    (cmdIndex),
    .resultValid (resultValid),
    .accept      (accept),
    .hashIndex   (hashIndex)
  );
endmodule

// File: tb/mcast_hash_filter_tb.sv
`timescale 1ns/1ps
module mcast_hash_filter_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteValid = 1'b0;
  logic        byteStart = 1'b0;
  logic [7:0]  byteData = '0;
  logic        wordValid = 1'b0;
  logic [47:0] addrWord = '0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        cmdSet = 1'b0;
  logic        cmdClr = 1'b0;
  logic [7:0]  cmdIndex = '0;
  logic        resultValid;
  logic        accept;
  logic [7:0]  hashIndex;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] mt [8];

  always #2.5 clk = ~clk;

  mcast_hash_filter dut_i (.*);

  // bit 48 = program this address into the table first
  localparam logic [48:0] VEC [6] = '{
    {1'b1, 48'h01_00_00_5E_00_01},
    {1'b1, 48'hFB_00_00_5E_00_01},
    {1'b0, 48'h33_00_00_00_33_33},
    {1'b1, 48'hFF_FF_FF_FF_FF_FF},
    {1'b0, 48'h12_34_56_78_9A_BD},
    {1'b1, 48'h55_44_33_22_11_02}   // unicast, bit still set
  };

  function automatic logic [7:0] refIdx(input logic [47:0] a);
    logic [31:0] c;
    logic fb;
    logic [7:0] h;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < 48; i++) begin
      fb = c[0] ^ a[i];
      c = c >> 1;
      if (fb) c = c ^ 32'hEDB88320;
    end
    for (int k = 0; k < 8; k++) h[7-k] = c[k];
    return h;
  endfunction

  function automatic logic refAcc(input logic [47:0] a);
    logic [7:0] h;
    h = refIdx(a);
    return a[0] & mt[h[7:5]][31 - h[4:0]];
  endfunction

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendBytes(input logic [47:0] a);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      byteValid = 1'b1; byteStart = (i == 0); byteData = a[8*i +: 8];
    end
    @(negedge clk);
    byteValid = 1'b0; byteStart = 1'b0;
  endtask

  task automatic sendWord(input logic [47:0] a);
    @(negedge clk);
    wordValid = 1'b1; addrWord = a;
    @(negedge clk);
    wordValid = 1'b0;
  endtask

  task automatic doCmd(input logic s, input logic c, input logic [7:0] idx);
    @(negedge clk);
    cmdSet = s; cmdClr = c; cmdIndex = idx;
    @(negedge clk);
    cmdSet = 1'b0; cmdClr = 1'b0;
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readCheck(input string req, input logic [2:0] a);
    @(negedge clk);
    regAddr = a;
    #1 check(req, {16'h0, regRdData}, {16'h0, mt[a]});
  endtask

  initial begin
    #1000000;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] h;
    for (int r = 0; r < 8; r++) mt[r] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R8: reset state
    #1 check("R8 resultValid", {47'h0, resultValid}, 48'h0);
    check("R8 accept", {47'h0, accept}, 48'h0);
    for (int r = 0; r < 8; r++) readCheck("R8 table zero", 3'(r));

    // R1 R2 R5 R6: program then look up every vector
    for (int v = 0; v < 6; v++) begin
      if (VEC[v][48]) begin
        h = refIdx(VEC[v][47:0]);
        doCmd(1'b1, 1'b0, h);
        mt[h[7:5]][31 - h[4:0]] = 1'b1;
        readCheck("R6 set readback", h[7:5]);
      end
    end
    for (int v = 0; v < 6; v++) begin
      sendBytes(VEC[v][47:0]);
      check("R3 resultValid byte mode", {47'h0, resultValid}, 48'h1);
      check("R1 hashIndex byte mode", {40'h0, hashIndex}, {40'h0, refIdx(VEC[v][47:0])});
      check("R2 R5 accept byte mode", {47'h0, accept}, {47'h0, refAcc(VEC[v][47:0])});
      @(negedge clk);
      check("R3 one-cycle pulse", {47'h0, resultValid}, 48'h0);
      sendWord(VEC[v][47:0]);
      check("R4 resultValid word mode", {47'h0, resultValid}, 48'h1);
      check("R4 hashIndex word mode", {40'h0, hashIndex}, {40'h0, refIdx(VEC[v][47:0])});
      check("R4 accept word mode", {47'h0, accept}, {47'h0, refAcc(VEC[v][47:0])});
    end
    check("R5 unicast rejected", {47'h0, accept}, 48'h0);

    // R2 corner entries: index 0 -> reg0 bit31, index 255 -> reg7 bit0
    regWrite(3'd0, 32'h0); mt[0] = 32'h0;
    regWrite(3'd7, 32'h0); mt[7] = 32'h0;
    doCmd(1'b1, 1'b0, 8'd0);   mt[0][31] = 1'b1;
    doCmd(1'b1, 1'b0, 8'd255); mt[7][0]  = 1'b1;
    @(negedge clk); regAddr = 3'd0; #1 check("R2 entry 0 is reg0 MSB", {16'h0, regRdData}, 48'h80000000);
    @(negedge clk); regAddr = 3'd7; #1 check("R2 entry 255 is reg7 LSB", {16'h0, regRdData}, 48'h00000001);

    // R6 clear keeps neighbours, clear beats set, write beats commands
    regWrite(3'd3, 32'hFFFF_FFFF); mt[3] = 32'hFFFF_FFFF;
    doCmd(1'b0, 1'b1, 8'h65); mt[3][31 - 5] = 1'b0;
    readCheck("R6 clear single entry", 3'd3);
    doCmd(1'b1, 1'b1, 8'h66); mt[3][31 - 6] = 1'b0;
    readCheck("R6 clear wins over set", 3'd3);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 3'd3; regWrData = 32'h0000_0000;
    cmdSet = 1'b1; cmdIndex = 8'h60;
    @(negedge clk);
    regWrEn = 1'b0; cmdSet = 1'b0; mt[3] = 32'h0;
    readCheck("R6 write drops command", 3'd3);

    // R7 plain write/read
    regWrite(3'd5, 32'hA5C3_0F81); mt[5] = 32'hA5C3_0F81;
    readCheck("R7 register write", 3'd5);

    // R9: row cleared on the same edge as the sixth byte
    h = refIdx(VEC[0][47:0]);
    regWrite(h[7:5], 32'hFFFF_FFFF); mt[h[7:5]] = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      byteValid = 1'b1; byteStart = (i == 0); byteData = VEC[0][8*i +: 8];
      if (i == 5) begin regWrEn = 1'b1; regAddr = h[7:5]; regWrData = 32'h0; end
    end
    @(negedge clk);
    byteValid = 1'b0; byteStart = 1'b0; regWrEn = 1'b0;
    check("R9 lookup uses old table", {47'h0, accept}, 48'h1);
    mt[h[7:5]] = 32'h0;
    sendWord(VEC[0][47:0]);
    check("R9 later lookup sees write", {47'h0, accept}, 48'h0);

    // R4 word aborts a byte sequence; R10 leftover bytes ignored
    regWrite(h[7:5], 32'hFFFF_FFFF); mt[h[7:5]] = 32'hFFFF_FFFF;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      byteValid = 1'b1; byteStart = (i == 0); byteData = VEC[3][8*i +: 8];
    end
    @(negedge clk);
    byteValid = 1'b0; byteStart = 1'b0;
    wordValid = 1'b1; addrWord = VEC[0][47:0];
    @(negedge clk);
    wordValid = 1'b0;
    check("R4 word result after abort", {40'h0, hashIndex}, {40'h0, refIdx(VEC[0][47:0])});
    check("R4 word accept after abort", {47'h0, accept}, 48'h1);
    for (int i = 3; i < 6; i++) begin
      @(negedge clk);
      byteValid = 1'b1; byteData = VEC[3][8*i +: 8];
      #1 check("R10 no result for stray bytes", {47'h0, resultValid}, 48'h0);
    end
    @(negedge clk);
    byteValid = 1'b0;
    #1 check("R10 still no result", {47'h0, resultValid}, 48'h0);

    // R3 gaps between bytes
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      byteValid = 1'b1; byteStart = (i == 0); byteData = VEC[1][8*i +: 8];
      @(negedge clk);
      byteValid = 1'b0; byteStart = 1'b0;
      if (i < 5) #1 check("R3 no early result", {47'h0, resultValid}, 48'h0);
    end
    check("R3 result after gapped bytes", {40'h0, hashIndex}, {40'h0, refIdx(VEC[1][47:0])});
    check("R3 resultValid gapped", {47'h0, resultValid}, 48'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule